// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a configuration bitstream into a target programmable device over a two-wire passive serial link: a serial clock (DCLK) and a single data line. A pulse on the start input runs a timed reset handshake with the target. The block drives an active-low configuration request output low for a fixed minimum time, then confirms that the target's active-low status line reports reset. After the request is released, it polls the status line at a fixed interval until the target reports ready, or until a profile-dependent limit is reached.

Once the target is ready and a short settling delay has passed, the block takes bytes from a valid/ready byte stream and shifts each one out least significant bit first. It optionally swaps the bit order of each byte first. When the last byte has gone out, the block checks that the status line is still high and, if the parameter enables it, that the configuration-done input is high. It then clocks out one all-zero byte so that the target can start up.

The result is reported on a busy flag, a done flag and a three-bit error code. The done flag and the error code hold their values until the next start. A parameter chooses between a short timing profile (0) and a long one (1), and another parameter gives the number of system clock cycles per microsecond. All handshake delays are counted in system clock cycles.

Top module: `ps_cfg_seq`

## Requirements
- R1: A start with partial_i high, given while idle, is refused. err_o becomes 1 on the next cycle, busy_o stays low, and cfg_req_n_o is never driven low.
- R2: An accepted start drives cfg_req_n_o low for exactly 2*CLK_PER_US system cycles.
- R3: If status_n_i is high when the request pulse ends, the run aborts with err_o = 2 and no DCLK edge is produced.
- R4: After the request is released, status_n_i is sampled once every 268*CLK_PER_US cycles. The block takes at most ceil(W/268) samples, where W is 1506 for profile 0 and 3000 for profile 1. If no sample is high, err_o = 3, and busy_o falls exactly (samples * 268*CLK_PER_US) cycles after the release.
- R5: After the sample that finds status_n_i high, at least 2*CLK_PER_US cycles (profile 0) or 10*CLK_PER_US cycles (profile 1) pass before the first DCLK rising edge.
- R6: Each byte appears on data_o at successive DCLK rising edges in the order bit 0 to bit 7. With lsb_first_i low at start, the byte is bit-reversed first, so the wire order is bit 7 down to bit 0.
- R7: If status_n_i is low once the last byte (byte_last_i high) has been shifted out, the run ends with err_o = 4 and no padding clocks.
- R8: With USE_CONF_DONE = 1, a low conf_done_i at the end of the stream ends the run with err_o = 5 and no padding clocks.
- R9: When the end checks pass, exactly 8 further DCLK periods with data_o = 0 follow. Then done_o rises and busy_o falls with err_o = 0.
- R10: byte_ready_o is high only while the block is in its shifting phase, no byte is in the shifter, and the last byte has not yet been taken.
- R11: done_o and err_o hold until the next start, which clears both. While err_o is non-zero, cfg_req_n_o is high, dclk_o is low and busy_o is low.
- R12: DCLK stays high for DCLK_HALF system cycles per period. data_o changes only while dclk_o is low, so it is stable at every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| partial_i | input | 1 | Start asks for partial reconfiguration (refused) |
| lsb_first_i | input | 1 | Stream bytes are already LSB-first ordered |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte is valid |
| byte_last_i | input | 1 | Byte is the final one of the stream |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| status_n_i | input | 1 | Target status, low means reset or error |
| conf_done_i | input | 1 | Target configuration-done indication |
| cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| dclk_o | output | 1 | Serial configuration clock |
| data_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run completed without error |
| err_o | output | 3 | Error code: 0 none, 1 refused, 2 no reset, 3 not ready, 4 status low at end, 5 done low at end |

## Verification
The hardest situations to reach are the ones the target causes: a status line that never reports reset, one that never reports ready, and one that drops during the stream. A behavioural target model in the bench follows the configuration request output and releases status a fixed time after the request ends. Mode flags make the model hold status high, keep it low, or force it low right after the last byte is handed over. The poll-exhaustion case is checked by counting the exact number of cycles between the request release and the fall of busy, which proves both the sampling interval and the sample limit.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_PARTIAL   = 3'd1,
    ERR_NO_RESET  = 3'd2,
    ERR_NOT_READY = 3'd3,
    ERR_CFG       = 3'd4,
    ERR_NO_DONE   = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PULSE,
    S_POLL,
    S_SETTLE,
    S_SHIFT,
    S_CHECK,
    S_PAD
  } seq_state_e;

  localparam int PULSE_US = 2;
  localparam int POLL_US  = 268;

  // upper bound on the time status may need to report ready
  function automatic int max_wait_us(input int profile);
    return (profile == 0) ? 1506 : 3000;
  endfunction

  // delay from status ready to the first DCLK edge
  function automatic int settle_us(input int profile);
    return (profile == 0) ? 2 : 10;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       empty_o,
  output logic       dclk_o,
  output logic       data_o
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] PH_RELOAD = PW'(HALF - 1);

  logic [7:0]    sreg_q;
  logic [2:0]    bit_q;
  logic [PW-1:0] ph_q;
  logic          active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q   <= '0;
      bit_q    <= '0;
      ph_q     <= '0;
      active_q <= 1'b0;
      dclk_o   <= 1'b0;
      data_o   <= 1'b0;
    end else if (load_i) begin
      // new byte: present bit 0 while DCLK is low
      sreg_q   <= byte_i;
      data_o   <= byte_i[0];
      bit_q    <= '0;
      ph_q     <= PH_RELOAD;
      active_q <= 1'b1;
      dclk_o   <= 1'b0;
    end else if (active_q) begin
      if (ph_q != '0) begin
        ph_q <= ph_q - 1'b1;
      end else begin
        ph_q <= PH_RELOAD;
        if (!dclk_o) begin
          dclk_o <= 1'b1;
        end else begin
          // falling edge: advance data, or finish the byte
          dclk_o <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
          end else begin
            bit_q  <= bit_q + 1'b1;
            sreg_q <= sreg_q >> 1;
            data_o <= sreg_q[1];
          end
        end
      end
    end
  end

  assign empty_o = !active_q;
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int CLK_PER_US    = 4,
  parameter int PROFILE       = 0,
  parameter int DCLK_HALF     = 2,
  parameter bit USE_CONF_DONE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       partial_i,
  input  logic       lsb_first_i,
  input  logic [7:0] byte_data_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  input  logic       status_n_i,
  input  logic       conf_done_i,
  output logic       cfg_req_n_o,
  output logic       dclk_o,
  output logic       data_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [2:0] err_o
);
  localparam int T_CFG_CYC  = PULSE_US * CLK_PER_US;
  localparam int POLL_CYC   = POLL_US * CLK_PER_US;
  localparam int MAX_POLLS  = (max_wait_us(PROFILE) + POLL_US - 1) / POLL_US;
  localparam int SETTLE_CYC = settle_us(PROFILE) * CLK_PER_US;
  localparam int TW         = $clog2(POLL_CYC + 1);
  localparam int PLW        = $clog2(MAX_POLLS + 1);

  seq_state_e     state_q;
  err_e           err_q;
  logic [PLW-1:0] polls_q;
  logic           lsb_q;
  logic           last_seen_q;

  logic           tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           tmr_zero;
  logic           sh_load;
  logic [7:0]     sh_byte;
  logic           sh_empty;
  logic           accept;
  logic           done_ok;

  assign byte_ready_o = (state_q == S_SHIFT) && sh_empty && !last_seen_q;
  assign accept       = byte_ready_o && byte_valid_i;
  assign done_ok      = conf_done_i || !USE_CONF_DONE;
  assign err_o        = err_q;

  ps_cfg_timer #(.W(TW)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  ps_cfg_shifter #(.HALF(DCLK_HALF)) i_shifter (
    .clk     (clk),
    .rst     (rst),
    .load_i  (sh_load),
    .byte_i  (sh_byte),
    .empty_o (sh_empty),
    .dclk_o  (dclk_o),
    .data_o  (data_o)
  );

  // timer reloads and shifter loads requested by the sequencer
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_byte  = '0;
    case (state_q)
      S_IDLE: begin
        if (start_i && !partial_i) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(T_CFG_CYC - 1);
        end
      end
      S_PULSE: begin
        if (tmr_zero && !status_n_i) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(POLL_CYC - 1);
        end
      end
      S_POLL: begin
        if (tmr_zero) begin
          if (status_n_i) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC - 1);
          end else if (polls_q != PLW'(MAX_POLLS - 1)) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(POLL_CYC - 1);
          end
        end
      end
      S_SHIFT: begin
        if (accept) begin
          sh_load = 1'b1;
          sh_byte = lsb_q ? byte_data_i : rev8(byte_data_i);
        end
      end
      S_CHECK: begin
        if (status_n_i && done_ok) begin
          sh_load = 1'b1;
          sh_byte = 8'h00;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      err_q       <= ERR_NONE;
      polls_q     <= '0;
      lsb_q       <= 1'b0;
      last_seen_q <= 1'b0;
      cfg_req_n_o <= 1'b1;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            done_o <= 1'b0;
            if (partial_i) begin
              err_q <= ERR_PARTIAL;
            end else begin
              err_q       <= ERR_NONE;
              busy_o      <= 1'b1;
              cfg_req_n_o <= 1'b0;
              lsb_q       <= lsb_first_i;
              last_seen_q <= 1'b0;
              state_q     <= S_PULSE;
            end
          end
        end
        S_PULSE: begin
          if (tmr_zero) begin
            cfg_req_n_o <= 1'b1;
            if (status_n_i) begin
              err_q   <= ERR_NO_RESET;
              busy_o  <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              polls_q <= '0;
              state_q <= S_POLL;
            end
          end
        end
        S_POLL: begin
          if (tmr_zero) begin
            if (status_n_i) begin
              state_q <= S_SETTLE;
            end else if (polls_q == PLW'(MAX_POLLS - 1)) begin
              err_q   <= ERR_NOT_READY;
              busy_o  <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              polls_q <= polls_q + 1'b1;
            end
          end
        end
        S_SETTLE: begin
          if (tmr_zero) state_q <= S_SHIFT;
        end
        S_SHIFT: begin
          if (accept && byte_last_i) last_seen_q <= 1'b1;
          if (last_seen_q && sh_empty) state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (!status_n_i) begin
            err_q   <= ERR_CFG;
            busy_o  <= 1'b0;
            state_q <= S_IDLE;
          end else if (!done_ok) begin
            err_q   <= ERR_NO_DONE;
            busy_o  <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_PAD;
          end
        end
        S_PAD: begin
          if (sh_empty) begin
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps_cfg_seq_chk.sv
module ps_cfg_seq_chk #(
  parameter int T_CFG_CYC = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       partial_i,
  input logic       cfg_req_n_o,
  input logic       byte_ready_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] err_o,
  input logic       dclk_o,
  input logic       data_o
);
  int low_cnt;

  always_ff @(posedge clk) begin
    if (rst)               low_cnt <= 0;
    else if (!cfg_req_n_o) low_cnt <= low_cnt + 1;
    else                   low_cnt <= 0;
  end

  // R1: a partial request while idle is refused and touches no pin
  assert_partial_refused_R1: assert property (@(posedge clk) disable iff (rst)
    (start_i && partial_i && !busy_o) |=> (err_o == 3'd1 && cfg_req_n_o && !busy_o));

  // R2: request pulse lasts the full minimum width
  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req_n_o) |-> (low_cnt == T_CFG_CYC));

  // R10: bytes are accepted only while a run is in progress and the request is released
  assert_ready_gate_R10: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |-> (busy_o && cfg_req_n_o));

  // R11: an error leaves every pin idle
  assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (err_o != 3'd0) |-> (!busy_o && cfg_req_n_o && !dclk_o));

  // R11: done and error never coexist
  assert_done_clean_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (err_o == 3'd0 && !busy_o));

  // R12: data is stable across each DCLK rising edge
  assert_data_stable_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_o) |-> $stable(data_o));

  // R3: no serial clock while the request is asserted
  assert_no_dclk_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_req_n_o |-> !dclk_o);
endmodule

bind ps_cfg_seq ps_cfg_seq_chk #(.T_CFG_CYC(T_CFG_CYC)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .partial_i    (partial_i),
  .cfg_req_n_o  (cfg_req_n_o),
  .byte_ready_o (byte_ready_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .dclk_o       (dclk_o),
  .data_o       (data_o)
);

// File: tb/test_ps_cfg_seq.sv
module test_ps_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 4;
  localparam int HALF       = 2;
  // expected timing taken from the requirements (profile 0)
  localparam int EXP_PULSE  = 2 * CPU;
  localparam int EXP_POLL   = 268 * CPU;
  localparam int EXP_NPOLL  = 6;              // ceil(1506/268)
  localparam int EXP_SETTLE = 2 * CPU;
  localparam int RISE       = 100;            // model: status rises 100 cycles after release
  localparam int WATCHDOG   = 150000;

  // vector: [16] lsb_first, [15:8] first byte, [7:0] last byte
  localparam logic [16:0] VEC [4] = '{
    {1'b1, 8'hA5, 8'h3C},
    {1'b0, 8'hA5, 8'h3C},
    {1'b0, 8'h01, 8'hF0},
    {1'b1, 8'h80, 8'h6E}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, partial = 1'b0, lsb = 1'b0;
  logic [7:0] bdata = '0;
  logic bvalid = 1'b0, blast = 1'b0;
  logic conf_done = 1'b1;
  logic status_n;
  logic byte_ready_o, cfg_req_n_o, dclk_o, data_o, busy_o, done_o;
  logic [2:0] err_o;

  // target model
  logic st_m = 1'b1;
  int   rcnt = RISE;
  bit   no_reset_mode = 0, never_rise = 0, force_low = 0;
  assign status_n = st_m & !force_low;

  int checks = 0, failures = 0, cyc = 0;
  int low_cnt = 0, rel_cnt = 0, pre_dclk = 0, hi_cnt = 0;
  logic cap [64];
  int cap_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_cfg_seq #(.CLK_PER_US(CPU), .PROFILE(0), .DCLK_HALF(HALF), .USE_CONF_DONE(1'b1)) i_ps_cfg_seq (
    .clk(clk), .rst(rst), .start_i(start), .partial_i(partial), .lsb_first_i(lsb),
    .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_last_i(blast), .byte_ready_o(byte_ready_o),
    .status_n_i(status_n), .conf_done_i(conf_done), .cfg_req_n_o(cfg_req_n_o),
    .dclk_o(dclk_o), .data_o(data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always @(negedge clk) begin
    if (!cfg_req_n_o) begin
      st_m <= no_reset_mode;
      rcnt <= 0;
    end else if (rcnt < RISE) begin
      rcnt <= rcnt + 1;
    end else begin
      st_m <= !never_rise;
    end
  end

  always @(negedge clk) begin
    if (!cfg_req_n_o) low_cnt++;
    if (cfg_req_n_o && busy_o) rel_cnt++;
    if (cfg_req_n_o && busy_o && cap_n == 0) pre_dclk++;
    if (dclk_o) hi_cnt++;
  end

  always @(posedge dclk_o) begin
    if (cap_n < 64) begin
      cap[cap_n] = data_o;
      cap_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic p, input logic l);
    @(posedge clk);
    low_cnt = 0; rel_cnt = 0; pre_dclk = 0; hi_cnt = 0; cap_n = 0;
    @(negedge clk);
    start = 1'b1; partial = p; lsb = l;
    @(negedge clk);
    start = 1'b0; partial = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last);
    while (!byte_ready_o) @(negedge clk);
    bdata = d; bvalid = 1'b1; blast = last;
    @(negedge clk);
    bvalid = 1'b0; blast = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [7:0] b, input logic l, input int i);
    return l ? b[i] : b[7-i];
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(cfg_req_n_o && !busy_o && !done_o && err_o == 0 && !dclk_o, "R11 reset state",
        {cfg_req_n_o, busy_o, done_o, dclk_o}, 4'b1000);
    chk(!byte_ready_o, "R10 ready low after reset", byte_ready_o, 0);

    // vector table: good runs
    for (int v = 0; v < 4; v++) begin
      logic l;
      logic [7:0] b0, b1;
      int mism, padbad;
      l = VEC[v][16]; b0 = VEC[v][15:8]; b1 = VEC[v][7:0];
      do_start(1'b0, l);
      @(negedge clk);
      chk(!byte_ready_o && !cfg_req_n_o, "R10 ready low during request pulse", byte_ready_o, 0);
      send_byte(b0, 1'b0);
      send_byte(b1, 1'b1);
      wait_idle();
      chk(done_o && err_o == 0 && !busy_o, "R9 done after good run", {done_o, err_o}, 8);
      chk(cap_n == 24, "R9 DCLK rising edge count", cap_n, 24);
      mism = 0;
      for (int i = 0; i < 8; i++) begin
        if (cap[i] !== exp_bit(b0, l, i)) mism++;
        if (cap[8+i] !== exp_bit(b1, l, i)) mism++;
      end
      chk(mism == 0, "R6 bit order mismatches", mism, 0);
      padbad = 0;
      for (int i = 16; i < 24; i++) if (cap[i] !== 1'b0) padbad++;
      chk(padbad == 0, "R9 padding bits non-zero", padbad, 0);
      chk(low_cnt == EXP_PULSE, "R2 request pulse width", low_cnt, EXP_PULSE);
      chk(pre_dclk >= EXP_POLL + EXP_SETTLE && pre_dclk <= EXP_POLL + EXP_SETTLE + 40,
          "R5 release to first DCLK", pre_dclk, EXP_POLL + EXP_SETTLE);
      chk(hi_cnt == 24 * HALF, "R12 DCLK high cycles", hi_cnt, 24 * HALF);
    end

    // done is sticky
    repeat (20) @(negedge clk);
    chk(done_o == 1'b1, "R11 done sticky", done_o, 1);

    // partial reconfiguration refused
    do_start(1'b1, 1'b0);
    chk(err_o == 3'd1 && !busy_o && !done_o, "R1 partial refused code", err_o, 1);
    repeat (10) @(negedge clk);
    chk(low_cnt == 0 && cfg_req_n_o, "R1 request never driven", low_cnt, 0);

    // no reset seen
    no_reset_mode = 1;
    do_start(1'b0, 1'b0);
    chk(err_o == 3'd0, "R11 new start clears error", err_o, 0);
    wait_idle();
    no_reset_mode = 0;
    chk(err_o == 3'd2, "R3 no reset error code", err_o, 2);
    chk(cap_n == 0 && !dclk_o && cfg_req_n_o, "R3 no DCLK after abort", cap_n, 0);

    // status never ready
    never_rise = 1;
    do_start(1'b0, 1'b0);
    wait_idle();
    never_rise = 0;
    chk(err_o == 3'd3, "R4 not ready error code", err_o, 3);
    chk(rel_cnt == EXP_NPOLL * EXP_POLL, "R4 polling window cycles", rel_cnt, EXP_NPOLL * EXP_POLL);
    repeat (20) @(negedge clk);
    chk(err_o == 3'd3 && cfg_req_n_o && !busy_o, "R11 error sticky and pins idle", err_o, 3);

    // status drops before end of stream
    do_start(1'b0, 1'b1);
    send_byte(8'h5A, 1'b0);
    send_byte(8'hC3, 1'b1);
    force_low = 1;
    wait_idle();
    force_low = 0;
    chk(err_o == 3'd4, "R7 status low at end code", err_o, 4);
    chk(cap_n == 16, "R7 no padding clocks", cap_n, 16);

    // config-done low at end
    conf_done = 1'b0;
    do_start(1'b0, 1'b0);
    send_byte(8'h12, 1'b1);
    wait_idle();
    conf_done = 1'b1;
    chk(err_o == 3'd5, "R8 config-done low code", err_o, 5);
    chk(cap_n == 8 && !done_o, "R8 no padding clocks", cap_n, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule